// File: doc/BRIEF.md
# Cascadable Synchronous Loadable Binary Counter

This block is a binary up-counter built from a chain of identical 4-bit stages that all share one clock. Every stage has an asynchronous active-low clear, a synchronous active-low parallel load, and two count enables. One enable, the parallel enable, goes to every stage. The other, the chain enable, enters only the least significant stage. Each stage's terminal-count carry drives the chain enable of the stage above it, so the chain forms one wide synchronous counter with no extra gating.

Each stage picks one of three synchronous operations on every rising edge. LOAD is chosen while load is low. COUNT is chosen while load is high and both enables are high. HOLD is chosen in every other case. CLEAR is not a clocked operation: it overrides all three at once, whatever the clock is doing.

The possible moves are as follows:
- Any state goes to zero as soon as clear is low.
- Any state goes to the preset value on an edge taken under LOAD.
- A value goes to itself plus one, modulo 2^WIDTH, on an edge taken under COUNT.
- A value stays where it is under HOLD.

The carry output is combinational. It follows the chain enable and the stored count without waiting for a clock edge.

Top module: `cascade_counter`

## Requirements
- R1: While `clr_n` is low, `count_q` is zero and `carry_out` is low. This takes effect at once, including in the middle of a clock period, whatever `load_n`, `cnt_en` and `chain_en` are.
- R2: With `clr_n` high and `load_n` low, a rising edge copies `preset_data` into `count_q`, even when both enables are low.
- R3: With `clr_n` and `load_n` high and both `cnt_en` and `chain_en` high, a rising edge adds one to `count_q`.
- R4: With `clr_n` and `load_n` high and either enable low, `count_q` keeps its value across a rising edge.
- R5: Incrementing from all ones gives zero across the full width.
- R6: `carry_out` is high exactly when `chain_en` is high and every bit of `count_q` is one. It follows a change on `chain_en` within the same clock period, with no edge needed.
- R7: Stage k (4-bit slice k, k = 0 being the least significant) advances only on an edge where every lower slice is at 15 and the enables allow counting. For example, 0x0F becomes 0x10.
- R8: Clear takes priority over load, and load takes priority over counting.
- R9: The state changes only on a rising edge. A pulse on an enable that has ended before the edge has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock, rising edge active |
| clr_n | input | 1 | Asynchronous clear, active low |
| load_n | input | 1 | Synchronous parallel load, active low |
| cnt_en | input | 1 | Parallel count enable, shared by every stage |
| chain_en | input | 1 | Chain enable into the least significant stage; also gates the carry |
| preset_data | input | STAGES*4 | Value taken on a load |
| count_q | output | STAGES*4 | Current count |
| carry_out | output | 1 | Full-width terminal-count carry |

## Verification
Results arrive on three different schedules:
- **Load, count and hold** settle one rising edge after the inputs are applied. The bench drives its inputs just after a falling edge and reads `count_q` at the next falling edge, so exactly one register stage lies between stimulus and sample.
- **Clear and carry** need no edge. The bench checks them after half a nanosecond, inside the same clock phase, including a clear raised while the clock is high.
- **Enable pulse between edges** is checked after the following edge, to show that it left no trace.

// File: rtl/ccnt_pkg.sv
package ccnt_pkg;
    localparam int unsigned NIB = 4;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_LOAD  = 2'd1,
        OP_COUNT = 2'd2
    } ccnt_op_t;
endpackage

// File: rtl/ccnt_opdecode.sv
module ccnt_opdecode
    import ccnt_pkg::*;
(
    input  logic     load_n,
    input  logic     pe,
    input  logic     te,
    output ccnt_op_t op
);
    // Load outranks counting; anything else holds.
    always_comb begin
        if (!load_n)
            op = OP_LOAD;
        else if (pe && te)
            op = OP_COUNT;
        else
            op = OP_HOLD;
    end
endmodule

// File: rtl/ccnt_stage.sv
module ccnt_stage
    import ccnt_pkg::*;
#(
    parameter int unsigned W = NIB
) (
    input  logic         clk,
    input  logic         clr_n,
    input  logic         load_n,
    input  logic         pe,
    input  logic         te,
    input  logic [W-1:0] din,
    output logic [W-1:0] q,
    output logic         tc
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    ccnt_op_t     op;
    logic [W-1:0] q_next;

    ccnt_opdecode u_dec (
        .load_n (load_n),
        .pe     (pe),
        .te     (te),
        .op     (op)
    );

    // Next-state selection
    always_comb begin
        unique case (op)
            OP_LOAD:  q_next = din;
            OP_COUNT: q_next = q + 1'b1;
            default:  q_next = q;
        endcase
    end

    // State register with asynchronous clear
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n)
            q <= '0;
        else
            q <= q_next;
    end

    // Look-ahead carry: combinational in te and stored value
    always_comb tc = te && (q == TOP);
endmodule

// File: rtl/cascade_counter.sv
module cascade_counter
    import ccnt_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic                  clk,
    input  logic                  clr_n,
    input  logic                  load_n,
    input  logic                  cnt_en,
    input  logic                  chain_en,
    input  logic [STAGES*NIB-1:0] preset_data,
    output logic [STAGES*NIB-1:0] count_q,
    output logic                  carry_out
);
    logic [STAGES:0] link;

    assign link[0] = chain_en;

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        ccnt_stage #(.W(NIB)) u_stage (
            .clk    (clk),
            .clr_n  (clr_n),
            .load_n (load_n),
            .pe     (cnt_en),
            .te     (link[k]),
            .din    (preset_data[k*NIB +: NIB]),
            .q      (count_q[k*NIB +: NIB]),
            .tc     (link[k+1])
        );
    end

    assign carry_out = link[STAGES];
endmodule

// File: rtl/cascade_counter_chk.sv
module cascade_counter_chk #(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         clr_n,
    input logic         load_n,
    input logic         cnt_en,
    input logic         chain_en,
    input logic [W-1:0] preset_data,
    input logic [W-1:0] count_q,
    input logic         carry_out
);
    always @(negedge clk) begin
        if (!clr_n) begin
            // R1
            clr_zero_chk: assert (count_q == '0 && !carry_out);
        end
    end

    // R2
    load_take_chk: assert property (@(posedge clk) disable iff (!clr_n)
        !load_n |=> count_q == $past(preset_data));

    // R3
    count_step_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && cnt_en && chain_en) |=> count_q == W'($past(count_q) + 1'b1));

    // R4
    hold_keep_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && !(cnt_en && chain_en)) |=> $stable(count_q));

    // R6
    carry_term_chk: assert property (@(posedge clk) disable iff (!clr_n)
        carry_out == (chain_en && (&count_q)));
endmodule

bind cascade_counter cascade_counter_chk #(.W(STAGES*ccnt_pkg::NIB)) u_chk (
    .clk         (clk),
    .clr_n       (clr_n),
    .load_n      (load_n),
    .cnt_en      (cnt_en),
    .chain_en    (chain_en),
    .preset_data (preset_data),
    .count_q     (count_q),
    .carry_out   (carry_out)
);

// File: tb/cascade_counter_bench.sv
`timescale 1ns/1ps
module cascade_counter_bench;
    localparam int STAGES = 2;
    localparam int W = STAGES * 4;

    logic         clk = 1'b0;
    logic         clr_n = 1'b0;
    logic         load_n = 1'b1;
    logic         cnt_en = 1'b0;
    logic         chain_en = 1'b0;
    logic [W-1:0] preset_data = '0;
    logic [W-1:0] count_q;
    logic         carry_out;

    int checks = 0;
    int errors = 0;
    logic [W-1:0] model = '0;

    always #2.5 clk = ~clk;

    cascade_counter #(.STAGES(STAGES)) u_cascade_counter (
        .clk         (clk),
        .clr_n       (clr_n),
        .load_n      (load_n),
        .cnt_en      (cnt_en),
        .chain_en    (chain_en),
        .preset_data (preset_data),
        .count_q     (count_q),
        .carry_out   (carry_out)
    );

    task automatic check_q(input string req, input logic [W-1:0] exp);
        checks++;
        if (count_q !== exp) begin
            errors++;
            $display("FAIL %s count_q actual %h expected %h", req, count_q, exp);
        end
    endtask

    task automatic check_c(input string req, input logic exp);
        checks++;
        if (carry_out !== exp) begin
            errors++;
            $display("FAIL %s carry_out actual %b expected %b", req, carry_out, exp);
        end
    endtask

    // one edge, then back to the falling edge
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        check_q("R1", '0);
        check_c("R1", 1'b0);
        @(negedge clk);
        clr_n = 1'b1;
    endtask

    task automatic t_load_enables_low();
        load_n = 1'b0; cnt_en = 1'b0; chain_en = 1'b0; preset_data = 8'hA5;
        model = 8'hA5;
        tick();
        load_n = 1'b1;
        check_q("R2", model);
    endtask

    task automatic t_hold();
        cnt_en = 1'b0; chain_en = 1'b1;
        tick();
        check_q("R4", model);
        cnt_en = 1'b1; chain_en = 1'b0;
        tick();
        check_q("R4", model);
    endtask

    task automatic t_count();
        cnt_en = 1'b1; chain_en = 1'b1;
        for (int i = 0; i < 5; i++) begin
            tick();
            model = model + 1'b1;
            check_q("R3", model);
        end
    endtask

    task automatic t_cascade();
        load_n = 1'b0; preset_data = 8'h0F; model = 8'h0F;
        tick();
        load_n = 1'b1;
        #0.5;
        check_c("R6", 1'b0);
        tick();
        model = 8'h10;
        check_q("R7", model);
    endtask

    task automatic t_carry_wrap();
        cnt_en = 1'b0; load_n = 1'b0; preset_data = 8'hFF; model = 8'hFF;
        tick();
        load_n = 1'b1; chain_en = 1'b0;
        #0.5;
        check_c("R6", 1'b0);
        chain_en = 1'b1;
        #0.5;
        check_c("R6", 1'b1);
        @(negedge clk);
        cnt_en = 1'b1;
        tick();
        model = 8'h00;
        check_q("R5", model);
        check_c("R6", 1'b0);
    endtask

    task automatic t_mid_clear();
        load_n = 1'b0; preset_data = 8'h33;
        tick();
        load_n = 1'b1; cnt_en = 1'b1; chain_en = 1'b1;
        @(posedge clk);
        #1;
        clr_n = 1'b0;
        #0.5;
        check_q("R1", '0);
        @(negedge clk);
        load_n = 1'b0; preset_data = 8'h77;
        tick();
        check_q("R8", '0);
        clr_n = 1'b1;
        model = '0;
    endtask

    task automatic t_load_over_count();
        load_n = 1'b0; cnt_en = 1'b1; chain_en = 1'b1; preset_data = 8'h42;
        model = 8'h42;
        tick();
        load_n = 1'b1; cnt_en = 1'b0;
        check_q("R8", model);
    endtask

    task automatic t_pulse_between_edges();
        cnt_en = 1'b0; chain_en = 1'b1;
        #0.5;
        cnt_en = 1'b1;
        #0.5;
        cnt_en = 1'b0;
        tick();
        check_q("R9", model);
    endtask

    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_load_enables_low();
        t_hold();
        t_count();
        t_cascade();
        t_carry_wrap();
        t_mid_clear();
        t_load_over_count();
        t_pulse_between_edges();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule